// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block holds the configuration state of several on-chip logical devices and makes it reachable through two byte-wide I/O locations. Software first writes a register number to the index location, then reads or writes that register through the data location. One of those registers holds the number of the logical device being configured. The per-device registers then act on the bank of the device it names, so every device shares the same small set of register numbers.

Each logical device has two pieces of state, and both leave the block as plain outputs: a one-bit enable and a 16-bit base address. A runtime address decoder elsewhere compares bus addresses against the base address and uses the enable to gate that device. The GPIO device (device 7 by default) also has a pin-select register and a pin-configuration register. A global register at index 22h is exported as a byte, and its bit 7 gates the watchdog device (device 4). Register contents take effect on the clock edge of the write. Reads are combinational while the read strobe is held.

Top module: `cfg_port`

## Requirements
- R1: A write on the bus to address 2Eh loads the index register. A read at 2Eh returns the index register. The index is 00h after reset.
- R2: Index 07h selects the logical device number register. It is read and written in full through the data port at 2Fh.
- R3: Index 30h holds the enable of the selected device in bit 0. Bits 7:1 read as 0 and their written values are dropped. `dev_active[n]` shows device n's enable from the cycle after the write.
- R4: Index 60h holds the high byte and index 61h the low byte of the selected device's base address. Device n's address appears on `dev_base[16n+15:16n]` from the cycle after the write.
- R5: A data-port write to index 30h, 60h or 61h changes only the bank of the device whose number is held at index 07h. All other banks keep their values.
- R6: When the device number equals the GPIO device number (7), index F0h is the pin-select register and index F1h is the pin-configuration register. Both are exported. With any other device number, these indices read 00h and writes to them are dropped.
- R7: Index 22h is a global byte register, independent of the device number. It is exported on `glob_cfg`, and bit 7 is the watchdog gate.
- R8: An index outside the set 07h, 22h, 30h, 60h, 61h, F0h, F1h reads 00h, and a write to it changes no output. A device number of NUM_DEV or more selects no bank: 30h/60h/61h then read 00h and writes to them are dropped.
- R9: After reset, every enable, the device number, the pin registers and the global register are 0. Device n's base address is BASE_ROOT + n*BASE_STEP (0400h + n*0040h by default).
- R10: `io_rdata` is 00h unless `io_rd` is high with `io_addr` at 2Eh or 2Fh. Bus writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O bus address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| dev_active | output | NUM_DEV | Enable of each logical device |
| dev_base | output | 16*NUM_DEV | Base address of each logical device, device n in bits 16n+15:16n |
| gpio_pin_sel | output | 8 | GPIO device pin-select register |
| gpio_pin_cfg | output | 8 | GPIO device pin-configuration register |
| glob_cfg | output | 8 | Global register (index 22h) |

## Verification
The bench builds the block with its default parameters: eight devices, the GPIO bank at device 7, and base defaults 0400h spaced by 0040h. With these values, device numbers from 8 upward are within reach and exercise the no-bank path. The pin registers can be reached both with and without the GPIO device selected. Random index and data sequences move between banks and are checked against a bench model of every bank. Directed cases cover the reset defaults, out-of-range device numbers, unused indices and foreign bus addresses.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam logic [7:0] IX_LDN  = 8'h07;
    localparam logic [7:0] IX_GLOB = 8'h22;
    localparam logic [7:0] IX_ACT  = 8'h30;
    localparam logic [7:0] IX_BHI  = 8'h60;
    localparam logic [7:0] IX_BLO  = 8'h61;
    localparam logic [7:0] IX_PSEL = 8'hF0;
    localparam logic [7:0] IX_PCFG = 8'hF1;

    typedef struct packed {
        logic        act;
        logic [15:0] base;
    } bank_t;

    typedef struct packed {
        logic [7:0] index;
        logic [7:0] ldn;
        logic [7:0] glob;
        logic [7:0] psel;
        logic [7:0] pcfg;
    } core_t;
endpackage

// File: rtl/cfg_busdec.sv
module cfg_busdec #(
    parameter logic [15:0] IDX_ADDR = 16'h002E,
    parameter logic [15:0] DAT_ADDR = 16'h002F
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    output logic        idx_wr,
    output logic        idx_rd,
    output logic        dat_wr,
    output logic        dat_rd
);
    always_comb begin
        idx_wr = io_wr && (io_addr == IDX_ADDR);
        idx_rd = io_rd && (io_addr == IDX_ADDR);
        dat_wr = io_wr && (io_addr == DAT_ADDR);
        dat_rd = io_rd && (io_addr == DAT_ADDR);
    end

    // the two port strobes never fire together
    p_port_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(idx_wr && dat_wr) && !(idx_rd && dat_rd));
endmodule

// File: rtl/cfg_ldev_bank.sv
module cfg_ldev_bank
    import cfg_pkg::*;
#(
    parameter logic [15:0] BASE_RST = 16'h0400
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [7:0]  index,
    input  logic [7:0]  wdata,
    output logic        active,
    output logic [15:0] base,
    output logic [7:0]  rd_val
);
    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we) begin
            case (index)
                IX_ACT:  bank_d.act        = wdata[0];
                IX_BHI:  bank_d.base[15:8] = wdata;
                IX_BLO:  bank_d.base[7:0]  = wdata;
                default: ;
            endcase
        end
        case (index)
            IX_ACT:  rd_val = {7'b0, bank_q.act};
            IX_BHI:  rd_val = bank_q.base[15:8];
            IX_BLO:  rd_val = bank_q.base[7:0];
            default: rd_val = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '{act: 1'b0, base: BASE_RST};
        else        bank_q <= bank_d;
    end

    assign active = bank_q.act;
    assign base   = bank_q.base;

    // a bank holds its state unless its own write strobe fires
    p_bank_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(active) && $stable(base));
    p_act_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && index == IX_ACT) |=> active == $past(wdata[0]));
endmodule

// File: rtl/cfg_port.sv
module cfg_port
    import cfg_pkg::*;
#(
    parameter int          NUM_DEV   = 8,
    parameter int          GPIO_LDN  = 7,
    parameter logic [15:0] IDX_ADDR  = 16'h002E,
    parameter logic [15:0] DAT_ADDR  = 16'h002F,
    parameter logic [15:0] BASE_ROOT = 16'h0400,
    parameter logic [15:0] BASE_STEP = 16'h0040
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           io_addr,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [7:0]            io_wdata,
    output logic [7:0]            io_rdata,
    output logic [NUM_DEV-1:0]    dev_active,
    output logic [NUM_DEV*16-1:0] dev_base,
    output logic [7:0]            gpio_pin_sel,
    output logic [7:0]            gpio_pin_cfg,
    output logic [7:0]            glob_cfg
);
    localparam logic [7:0] GPIO_NUM = 8'(GPIO_LDN);
    localparam logic [8:0] DEV_LIM  = 9'(NUM_DEV);

    logic idx_wr, idx_rd, dat_wr, dat_rd;
    core_t core_d, core_q;
    logic [NUM_DEV-1:0] bank_we;
    logic [7:0] bank_rd [NUM_DEV];
    logic [7:0] dat_val;
    logic       gpio_sel;

    cfg_busdec #(.IDX_ADDR(IDX_ADDR), .DAT_ADDR(DAT_ADDR)) u_dec (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .idx_wr(idx_wr), .idx_rd(idx_rd), .dat_wr(dat_wr), .dat_rd(dat_rd)
    );

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_bank
        localparam logic [15:0] RST_I = 16'(BASE_ROOT + BASE_STEP * i);
        assign bank_we[i] = dat_wr && (core_q.ldn == 8'(i));
        cfg_ldev_bank #(.BASE_RST(RST_I)) u_bank (
            .clk(clk), .rst_n(rst_n), .we(bank_we[i]), .index(core_q.index),
            .wdata(io_wdata), .active(dev_active[i]),
            .base(dev_base[16*i +: 16]), .rd_val(bank_rd[i])
        );
    end

    always_comb begin
        core_d   = core_q;
        gpio_sel = (core_q.ldn == GPIO_NUM);
        if (idx_wr) core_d.index = io_wdata;
        if (dat_wr) begin
            case (core_q.index)
                IX_LDN:  core_d.ldn  = io_wdata;
                IX_GLOB: core_d.glob = io_wdata;
                IX_PSEL: if (gpio_sel) core_d.psel = io_wdata;
                IX_PCFG: if (gpio_sel) core_d.pcfg = io_wdata;
                default: ;
            endcase
        end
        dat_val = 8'h00;
        case (core_q.index)
            IX_LDN:  dat_val = core_q.ldn;
            IX_GLOB: dat_val = core_q.glob;
            IX_PSEL: dat_val = gpio_sel ? core_q.psel : 8'h00;
            IX_PCFG: dat_val = gpio_sel ? core_q.pcfg : 8'h00;
            default: begin
                for (int i = 0; i < NUM_DEV; i++)
                    if (core_q.ldn == 8'(i)) dat_val = bank_rd[i];
            end
        endcase
        io_rdata = idx_rd ? core_q.index : (dat_rd ? dat_val : 8'h00);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign gpio_pin_sel = core_q.psel;
    assign gpio_pin_cfg = core_q.pcfg;
    assign glob_cfg     = core_q.glob;

    p_idx_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> core_q.index == $past(io_wdata));
    p_one_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));
    p_no_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, core_q.ldn} >= DEV_LIM) |=> $stable(dev_active) && $stable(dev_base));
    p_pins_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.ldn != GPIO_NUM) |=> $stable(gpio_pin_sel) && $stable(gpio_pin_cfg));
    p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> io_rdata == 8'h00);
endmodule

// File: tb/cfg_port_tb.sv
`timescale 1ns/1ps
module cfg_port_tb;
    localparam int ND = 8;
    logic clk = 0, rst_n = 0;
    logic [15:0] io_addr = 0;
    logic io_wr = 0, io_rd = 0;
    logic [7:0] io_wdata = 0, io_rdata;
    logic [ND-1:0] dev_active;
    logic [ND*16-1:0] dev_base;
    logic [7:0] gpio_pin_sel, gpio_pin_cfg, glob_cfg;

    int checks = 0, fails = 0;
    bit done = 0;

    // model
    logic [7:0] m_idx, m_ldn, m_glob, m_psel, m_pcfg;
    logic m_act [ND];
    logic [15:0] m_base [ND];

    always #2 clk = ~clk;

    cfg_port u_dut (.clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .dev_active(dev_active), .dev_base(dev_base), .gpio_pin_sel(gpio_pin_sel),
        .gpio_pin_cfg(gpio_pin_cfg), .glob_cfg(glob_cfg));

    task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    function automatic void model_reset();
        m_idx = 0; m_ldn = 0; m_glob = 0; m_psel = 0; m_pcfg = 0;
        for (int i = 0; i < ND; i++) begin
            m_act[i] = 0;
            m_base[i] = 16'h0400 + 16'(i) * 16'h0040;
        end
    endfunction

    function automatic logic [7:0] exp_data();
        case (m_idx)
            8'h07: return m_ldn;
            8'h22: return m_glob;
            8'hF0: return (m_ldn == 7) ? m_psel : 8'h00;
            8'hF1: return (m_ldn == 7) ? m_pcfg : 8'h00;
            8'h30: return (m_ldn < ND) ? {7'b0, m_act[m_ldn[2:0]]} : 8'h00;
            8'h60: return (m_ldn < ND) ? m_base[m_ldn[2:0]][15:8] : 8'h00;
            8'h61: return (m_ldn < ND) ? m_base[m_ldn[2:0]][7:0] : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void model_wr(logic [15:0] a, logic [7:0] d);
        if (a == 16'h002E) m_idx = d;
        else if (a == 16'h002F) begin
            case (m_idx)
                8'h07: m_ldn = d;
                8'h22: m_glob = d;
                8'hF0: if (m_ldn == 7) m_psel = d;
                8'hF1: if (m_ldn == 7) m_pcfg = d;
                8'h30: if (m_ldn < ND) m_act[m_ldn[2:0]] = d[0];
                8'h60: if (m_ldn < ND) m_base[m_ldn[2:0]][15:8] = d;
                8'h61: if (m_ldn < ND) m_base[m_ldn[2:0]][7:0] = d;
                default: ;
            endcase
        end
    endfunction

    function automatic logic [255:0] exp_outs();
        logic [ND-1:0] a;
        logic [ND*16-1:0] b;
        for (int i = 0; i < ND; i++) begin
            a[i] = m_act[i];
            b[16*i +: 16] = m_base[i];
        end
        return {a, b, m_psel, m_pcfg, m_glob};
    endfunction

    function automatic logic [255:0] dut_outs();
        return {dev_active, dev_base, gpio_pin_sel, gpio_pin_cfg, glob_cfg};
    endfunction

    task automatic bus_wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1;
        @(negedge clk);
        io_wr = 0;
        model_wr(a, d);
    endtask

    task automatic bus_rd(logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1;
        #1 d = io_rdata;
        io_rd = 0;
    endtask

    task automatic rd_chk(string tag, logic [15:0] a);
        logic [7:0] d;
        logic [7:0] e;
        e = (a == 16'h002E) ? m_idx : (a == 16'h002F) ? exp_data() : 8'h00;
        bus_rd(a, d);
        chk(tag, 256'(d), 256'(e));
    endtask

    function automatic logic [7:0] pick_idx();
        case ($urandom % 9)
            0: return 8'h07; 1: return 8'h22; 2: return 8'h30;
            3: return 8'h60; 4: return 8'h61; 5: return 8'hF0;
            6: return 8'hF1; 7: return 8'h07;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        #(4.0 * 190000);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9 reset state
        @(negedge clk);
        chk("R9 reset outputs", dut_outs(), exp_outs());
        rd_chk("R1 reset index", 16'h002E);
        // R2 device number
        bus_wr(16'h002E, 8'h07); rd_chk("R1 index readback", 16'h002E);
        bus_wr(16'h002F, 8'h04); rd_chk("R2 ldn readback", 16'h002F);
        // R3 enable, upper bits dropped
        bus_wr(16'h002E, 8'h30); bus_wr(16'h002F, 8'hFF);
        chk("R3 dev_active", dut_outs(), exp_outs());
        rd_chk("R3 act read", 16'h002F);
        // R4 base bytes
        bus_wr(16'h002E, 8'h60); bus_wr(16'h002F, 8'hA5);
        bus_wr(16'h002E, 8'h61); bus_wr(16'h002F, 8'h3C);
        chk("R4 dev_base", dut_outs(), exp_outs());
        rd_chk("R4 low byte read", 16'h002F);
        // R6 pins without GPIO selected are dropped
        bus_wr(16'h002E, 8'hF0); bus_wr(16'h002F, 8'h55);
        chk("R6 pins ignored off gpio", dut_outs(), exp_outs());
        rd_chk("R6 pin read off gpio", 16'h002F);
        // R6 with GPIO selected
        bus_wr(16'h002E, 8'h07); bus_wr(16'h002F, 8'h07);
        bus_wr(16'h002E, 8'hF1); bus_wr(16'h002F, 8'h46);
        bus_wr(16'h002E, 8'hF0); bus_wr(16'h002F, 8'h45);
        chk("R6 pins gpio", dut_outs(), exp_outs());
        rd_chk("R6 pin read gpio", 16'h002F);
        // R7 global
        bus_wr(16'h002E, 8'h22); bus_wr(16'h002F, 8'h80);
        chk("R7 glob", dut_outs(), exp_outs());
        rd_chk("R7 glob read", 16'h002F);
        // R8 out of range device and unused index
        bus_wr(16'h002E, 8'h07); bus_wr(16'h002F, 8'h09);
        bus_wr(16'h002E, 8'h60); bus_wr(16'h002F, 8'h77);
        chk("R8 no bank write", dut_outs(), exp_outs());
        rd_chk("R8 no bank read", 16'h002F);
        bus_wr(16'h002E, 8'h45); bus_wr(16'h002F, 8'h99);
        chk("R8 unused index write", dut_outs(), exp_outs());
        rd_chk("R8 unused index read", 16'h002F);
        // R10 foreign address
        bus_wr(16'h012F, 8'h11);
        chk("R10 foreign write", dut_outs(), exp_outs());
        rd_chk("R10 foreign read", 16'h002D);
        // R5 random banking traffic
        for (int n = 0; n < 1500; n++) begin
            case ($urandom % 6)
                0: bus_wr(16'h002E, pick_idx());
                1: begin
                    if (m_idx == 8'h07) bus_wr(16'h002F, 8'($urandom % 10));
                    else bus_wr(16'h002F, 8'($urandom));
                end
                2: bus_wr(16'h002F, 8'($urandom));
                3: rd_chk("R5 random data read", 16'h002F);
                4: rd_chk("R1 random index read", 16'h002E);
                default: bus_wr(16'($urandom % 64), 8'($urandom));
            endcase
            chk("R5 random outputs", dut_outs(), exp_outs());
        end
        report();
    end
endmodule